// File: doc/BRIEF.md
# Handshaking Wait-State Generator

This block sits between a CPU bus and one slow parallel peripheral. It stretches a bus access until the peripheral can complete it, so no fixed access latency is needed. An address-match input, decoded elsewhere, qualifies the CPU read and write strobes.

On a read, the block raises a request toward the input device and holds the CPU's wait line high. When the device presents valid data, the block loads that data into its own data register and releases wait. On a write, the block captures the CPU data into an output register and offers it to the device with a valid flag. It holds wait high until the device signals that it accepts the data.

After either access completes, the block does nothing further until the CPU drops the strobe of that access. Each strobe assertion therefore produces exactly one transfer.

Top module: `hs_wait_gen`

## Requirements
- R1: With the block idle, `bus_sel` and `bus_rd` both high are sampled at a clock edge. After that edge, `dev_req` and `bus_wait` are both high.
- R2: While a read is pending, `dev_req` stays high until `dev_in_vld` is sampled high. `bus_wait` is high in every cycle in which `dev_req` is high.
- R3: At the edge that samples `dev_in_vld` high during a pending read, `bus_rdata` takes `dev_in_data`, and `dev_req` and `bus_wait` both go low. With the device answering L cycles after the request appears, `bus_wait` is high for exactly L+1 cycles.
- R4: `bus_rdata` changes only at the load edge of R3. A `dev_in_vld` outside a pending read is ignored.
- R5: With the block idle, `bus_sel` and `bus_wr` both high (and `bus_rd` low) are sampled at a clock edge. After that edge, `dev_out_data` holds the `bus_wdata` sampled at that edge, and `dev_out_vld` and `bus_wait` are high. `dev_out_data` stays stable while `dev_out_vld` is high, whatever `bus_wdata` does.
- R6: `dev_out_vld` and `bus_wait` go low after the edge that samples `dev_out_rdy` high while `dev_out_vld` is high. Readiness arriving L cycles after valid gives L+1 wait cycles. `dev_out_rdy` outside a pending write is ignored.
- R7: After an access completes, no new request or valid is issued while that strobe stays qualified. A new access needs the strobe to be sampled low first.
- R8: If read and write strobes are both qualified in the same cycle, the read is served and the write is ignored.
- R9: With `bus_sel` low, the strobes start nothing.
- R10: The synchronous active-high `rst` drives `bus_wait`, `dev_req`, `dev_out_vld`, `bus_rdata` and `dev_out_data` to zero, including in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Decoded address match for this device |
| bus_rd | input | 1 | CPU read strobe |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | DW | CPU write data |
| bus_rdata | output | DW | Data register driven back to the CPU |
| bus_wait | output | 1 | Stretch request to the CPU |
| dev_req | output | 1 | Data request to the input device |
| dev_in_vld | input | 1 | Input device presents valid data |
| dev_in_data | input | DW | Input device data |
| dev_out_vld | output | 1 | Output data valid toward the output device |
| dev_out_rdy | input | 1 | Output device accepts data |
| dev_out_data | output | DW | Captured write data toward the output device |

## Verification
Two events can coincide with the start of a stretch. The device can answer in the very first cycle its request or valid is visible, and the CPU can leave the strobe qualified in the cycle the stretch ends. The bench provokes the first case with zero-latency table entries: `dev_in_vld` or `dev_out_rdy` is driven during the first cycle of the handshake. It then expects exactly one wait cycle and the correct data. For the second case, the bench holds the strobe high for two cycles after release. It judges that no second request or valid appears and that the read data does not move.

// File: rtl/hs_wait_pkg.sv
package hs_wait_pkg;
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_BUSY = 2'd1,
    CH_DONE = 2'd2
  } ch_state_t;
endpackage

// File: rtl/hs_rd_chan.sv
module hs_rd_chan
  import hs_wait_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          stb,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  output logic          req,
  output logic          stall,
  output logic [DW-1:0] data_q,
  output logic          idle
);
  ch_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= CH_IDLE;
      req    <= 1'b0;
      stall  <= 1'b0;
      data_q <= '0;
    end else begin
      unique case (st)
        CH_IDLE: if (go) begin
          st    <= CH_BUSY;
          req   <= 1'b1;
          stall <= 1'b1;
        end
        CH_BUSY: if (in_vld) begin
          st     <= CH_DONE;
          req    <= 1'b0;
          stall  <= 1'b0;
          data_q <= in_data;
        end
        CH_DONE: if (!stb) st <= CH_IDLE;
        default: st <= CH_IDLE;
      endcase
    end
  end

  assign idle = (st == CH_IDLE);
endmodule

// File: rtl/hs_wr_chan.sv
module hs_wr_chan
  import hs_wait_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          stb,
  input  logic [DW-1:0] wdata,
  input  logic          rdy,
  output logic          vld,
  output logic          stall,
  output logic [DW-1:0] data_q,
  output logic          idle
);
  ch_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= CH_IDLE;
      vld    <= 1'b0;
      stall  <= 1'b0;
      data_q <= '0;
    end else begin
      unique case (st)
        CH_IDLE: if (go) begin
          st     <= CH_BUSY;
          vld    <= 1'b1;
          stall  <= 1'b1;
          data_q <= wdata;
        end
        CH_BUSY: if (rdy) begin
          st    <= CH_DONE;
          vld   <= 1'b0;
          stall <= 1'b0;
        end
        CH_DONE: if (!stb) st <= CH_IDLE;
        default: st <= CH_IDLE;
      endcase
    end
  end

  assign idle = (st == CH_IDLE);
endmodule

// File: rtl/hs_wait_gen.sv
module hs_wait_gen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_wait,
  output logic          dev_req,
  input  logic          dev_in_vld,
  input  logic [DW-1:0] dev_in_data,
  output logic          dev_out_vld,
  input  logic          dev_out_rdy,
  output logic [DW-1:0] dev_out_data
);
  logic rd_stb, wr_stb;
  logic rd_idle, wr_idle;
  logic rd_stall, wr_stall;

  assign rd_stb = bus_sel & bus_rd;
  assign wr_stb = bus_sel & bus_wr;

  hs_rd_chan #(.DW(DW)) rd_i (
    .clk     (clk),
    .rst     (rst),
    .go      (rd_stb & wr_idle),
    .stb     (rd_stb),
    .in_vld  (dev_in_vld),
    .in_data (dev_in_data),
    .req     (dev_req),
    .stall   (rd_stall),
    .data_q  (bus_rdata),
    .idle    (rd_idle)
  );

  hs_wr_chan #(.DW(DW)) wr_i (
    .clk     (clk),
    .rst     (rst),
    .go      (wr_stb & ~rd_stb & rd_idle),
    .stb     (wr_stb),
    .wdata   (bus_wdata),
    .rdy     (dev_out_rdy),
    .vld     (dev_out_vld),
    .stall   (wr_stall),
    .data_q  (dev_out_data),
    .idle    (wr_idle)
  );

  assign bus_wait = rd_stall | wr_stall;
endmodule

// File: rtl/hs_wait_gen_chk.sv
module hs_wait_gen_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wait,
  input logic          dev_req,
  input logic          dev_in_vld,
  input logic [DW-1:0] dev_in_data,
  input logic [DW-1:0] bus_rdata,
  input logic          dev_out_vld,
  input logic          dev_out_rdy,
  input logic [DW-1:0] dev_out_data
);
  a_r2_req_holds_wait: assert property (@(posedge clk) disable iff (rst)
    dev_req |-> bus_wait);

  a_r3_load_on_valid: assert property (@(posedge clk) disable iff (rst)
    (dev_req && dev_in_vld) |=> (bus_rdata == $past(dev_in_data)) && !dev_req);

  a_r4_rdata_quiet: assert property (@(posedge clk) disable iff (rst)
    !dev_req |=> $stable(bus_rdata));

  a_r5_out_data_stable: assert property (@(posedge clk) disable iff (rst)
    (dev_out_vld && $past(dev_out_vld)) |-> $stable(dev_out_data));

  a_r6_write_release: assert property (@(posedge clk) disable iff (rst)
    (dev_out_vld && dev_out_rdy) |=> !dev_out_vld);

  a_r8_one_side: assert property (@(posedge clk) disable iff (rst)
    !(dev_req && dev_out_vld));
endmodule

bind hs_wait_gen hs_wait_gen_chk #(.DW(DW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .bus_wait     (bus_wait),
  .dev_req      (dev_req),
  .dev_in_vld   (dev_in_vld),
  .dev_in_data  (dev_in_data),
  .bus_rdata    (bus_rdata),
  .dev_out_vld  (dev_out_vld),
  .dev_out_rdy  (dev_out_rdy),
  .dev_out_data (dev_out_data)
);

// File: tb/hs_wait_gen_tb_top.sv
module hs_wait_gen_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_wait, dev_req, dev_out_vld;
  logic          dev_in_vld = 1'b0, dev_out_rdy = 1'b0;
  logic [DW-1:0] dev_in_data = '0;
  logic [DW-1:0] dev_out_data;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  hs_wait_gen #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
    .dev_req(dev_req), .dev_in_vld(dev_in_vld), .dev_in_data(dev_in_data),
    .dev_out_vld(dev_out_vld), .dev_out_rdy(dev_out_rdy), .dev_out_data(dev_out_data)
  );

  // {is_write, data, device latency, expected wait cycles}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'hA5, 4'd0, 4'd1},
    {1'b0, 8'h3C, 4'd3, 4'd4},
    {1'b1, 8'h5A, 4'd0, 4'd1},
    {1'b1, 8'hC3, 4'd2, 4'd3},
    {1'b0, 8'h00, 4'd5, 4'd6},
    {1'b1, 8'hFF, 4'd4, 4'd5}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_read(input logic [DW-1:0] d, input int lat, input int expw);
    int wcnt;
    logic [DW-1:0] prev;
    prev = bus_rdata;
    bus_sel = 1'b1; bus_rd = 1'b1;
    tick();
    chk(dev_req && bus_wait, "R1 req/wait after read strobe", {dev_req, bus_wait}, 2'b11);
    wcnt = int'(bus_wait);
    for (int i = 0; i < lat; i++) begin
      dev_in_data = ~d;
      tick();
      wcnt += int'(bus_wait);
      chk(dev_req, "R2 request held", dev_req, 1);
      chk(bus_rdata == prev, "R4 rdata stable while pending", bus_rdata, prev);
    end
    dev_in_vld = 1'b1; dev_in_data = d;
    tick();
    dev_in_vld = 1'b0;
    wcnt += int'(bus_wait);
    chk(bus_rdata == d, "R3 rdata loaded", bus_rdata, d);
    chk(!dev_req && wcnt == expw, "R3 wait cycle count", wcnt, expw);
    for (int i = 0; i < 2; i++) begin
      tick();
      chk(!dev_req && !bus_wait && bus_rdata == d, "R7 no re-request while strobe held",
          {dev_req, bus_wait}, 0);
    end
    bus_sel = 1'b0; bus_rd = 1'b0;
    tick();
  endtask

  task automatic do_write(input logic [DW-1:0] d, input int lat, input int expw);
    int wcnt;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
    tick();
    bus_wdata = ~d;
    chk(dev_out_vld && bus_wait && dev_out_data == d, "R5 capture and valid",
        dev_out_data, d);
    wcnt = int'(bus_wait);
    for (int i = 0; i < lat; i++) begin
      tick();
      wcnt += int'(bus_wait);
      chk(dev_out_vld && dev_out_data == d, "R5 held while not ready", dev_out_data, d);
    end
    dev_out_rdy = 1'b1;
    tick();
    dev_out_rdy = 1'b0;
    wcnt += int'(bus_wait);
    chk(!dev_out_vld && wcnt == expw, "R6 wait cycle count", wcnt, expw);
    for (int i = 0; i < 2; i++) begin
      tick();
      chk(!dev_out_vld && !bus_wait, "R7 no re-offer while strobe held", dev_out_vld, 0);
    end
    bus_sel = 1'b0; bus_wr = 1'b0;
    tick();
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] keep;
    tick(); tick();
    rst = 1'b0;
    chk(!bus_wait && !dev_req && !dev_out_vld && bus_rdata == 0 && dev_out_data == 0,
        "R10 reset state", {bus_wait, dev_req, dev_out_vld}, 0);

    for (int v = 0; v < 6; v++) begin
      if (VEC[v][16]) do_write(VEC[v][15:8], int'(VEC[v][7:4]), int'(VEC[v][3:0]));
      else            do_read (VEC[v][15:8], int'(VEC[v][7:4]), int'(VEC[v][3:0]));
    end

    // R4: stray input valid while idle
    keep = bus_rdata;
    dev_in_vld = 1'b1; dev_in_data = 8'hEE;
    tick(); tick();
    dev_in_vld = 1'b0;
    chk(bus_rdata == keep && !dev_req, "R4 stray valid ignored", bus_rdata, keep);

    // R6: stray ready while idle
    keep = dev_out_data;
    dev_out_rdy = 1'b1;
    tick(); tick();
    dev_out_rdy = 1'b0;
    chk(!dev_out_vld && dev_out_data == keep && !bus_wait, "R6 stray ready ignored",
        dev_out_data, keep);

    // R9: strobes without address match
    bus_rd = 1'b1; bus_wr = 1'b0;
    tick(); tick();
    chk(!dev_req && !bus_wait, "R9 read without select", {dev_req, bus_wait}, 0);
    bus_rd = 1'b0; bus_wr = 1'b1; bus_wdata = 8'h11;
    tick(); tick();
    chk(!dev_out_vld && !bus_wait, "R9 write without select", dev_out_vld, 0);
    bus_wr = 1'b0;
    tick();

    // R8: read and write together
    keep = dev_out_data;
    bus_sel = 1'b1; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h77;
    tick();
    chk(dev_req && !dev_out_vld && dev_out_data == keep, "R8 read wins",
        {dev_req, dev_out_vld}, 2'b10);
    dev_in_vld = 1'b1; dev_in_data = 8'h42;
    tick();
    dev_in_vld = 1'b0;
    chk(bus_rdata == 8'h42 && !bus_wait, "R8 read completes", bus_rdata, 8'h42);
    tick();
    chk(!dev_out_vld, "R8 write not started", dev_out_vld, 0);
    bus_sel = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
    tick();

    // R10: reset in the middle of a read
    bus_sel = 1'b1; bus_rd = 1'b1;
    tick();
    rst = 1'b1; bus_sel = 1'b0; bus_rd = 1'b0;
    tick();
    chk(!bus_wait && !dev_req && !dev_out_vld && bus_rdata == 0 && dev_out_data == 0,
        "R10 reset mid-access", {bus_wait, dev_req, dev_out_vld}, 0);
    rst = 1'b0;
    tick();

    do_read(8'h96, 1, 2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule